// File: doc/BRIEF.md
# Unaligned Access Splitter for an Aligned 64-bit Bus

This block sits between a processor's load/store port and a 64-bit system bus that only carries transfers aligned to an 8-byte boundary. The processor presents an access of 1, 2, 4 or 8 bytes at any byte address. The block turns it into one or two bus transactions. Each transaction has an address phase that carries an ID and a length field, which the slave must accept. A data phase follows, tagged with the same ID, and in that phase the byte-lane enables select the bytes involved.

An access that fits inside one aligned 8-byte word needs a single transaction with only its own lanes enabled. An access that crosses the boundary is split into two transactions with complementary lane masks. The lower word goes first and the two halves use consecutive IDs. On a load, the bytes of the two returned words are shifted back into place in little-endian order, and the bytes of unused lanes are dropped. On a store, the block can wait for a write acknowledge from the bus before it reports completion. It answers the processor once, after the last half has finished.

Top module: `unaligned_bus_splitter`

## Requirements
- R1: After reset the block is ready for a request (`reqReady`=1) and drives `busAddrValid`, `busWdataValid` and `respValid` low.
- R2: Every bus address has its three low bits zero, and `busLen` is always 0, because a transaction is one beat and the length is coded as beats minus one.
- R3: `reqSize` codes the width as 0=1, 1=2, 2=4, 3=8 bytes. Lane i is bits 8i+7:8i and holds the byte whose address ends in i. An access that fits in one aligned word makes one transaction whose enabled lanes are exactly offset to offset+width-1.
- R4: An access whose last byte lies in the next aligned word makes two transactions. The first goes to the aligned base, the second to base+8, and the second uses the lanes left over after the first.
- R5: The address, ID and write flag are held until `busAddrReady` is seen. The data phase of a transaction begins only after its address was accepted, and it carries the same ID.
- R6: Transaction IDs count up by one per transaction, modulo 2^ID_W, starting at 0 after reset.
- R7: On a store, byte k of `reqWdata` (bits 8k+7:8k) is driven on the lane of byte address addr+k.
- R8: On a load, byte k of `respRdata` is the byte at address addr+k, taken from the matching word. Bytes at or above the access width are zero. A read beat whose `busRdataId` differs from the current ID is ignored.
- R9: With write acknowledge enabled, a store transaction is finished only when `busWackValid` arrives with the matching ID. No second address and no `respValid` appear before it.
- R10: `respValid` is a single-cycle pulse after the last transaction of a request. In the following cycle the block is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request strobe, taken while reqReady is high |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | Width code: 0=1, 1=2, 2=4, 3=8 bytes |
| reqWdata | input | DATA_W | Store data, least significant byte first |
| respValid | output | 1 | Request finished (one cycle) |
| respRdata | output | DATA_W | Load result, right-aligned and zero-extended |
| busAddrValid | output | 1 | Address phase valid |
| busAddrReady | input | 1 | Slave accepts the address |
| busAddr | output | ADDR_W | Aligned transaction address |
| busId | output | ID_W | Transaction ID |
| busLen | output | LEN_W | Beats minus one, always 0 |
| busWrite | output | 1 | Transaction direction |
| busWdataValid | output | 1 | Write data phase valid |
| busWdataReady | input | 1 | Slave takes the write beat |
| busWdataId | output | ID_W | ID of the write beat |
| busWdata | output | DATA_W | Write beat |
| busStrb | output | DATA_W/8 | Byte-lane enables |
| busRdataValid | input | 1 | Read beat valid |
| busRdataReady | output | 1 | Block waiting for a read beat |
| busRdataId | input | ID_W | ID of the read beat |
| busRdata | input | DATA_W | Read beat |
| busWackValid | input | 1 | Write acknowledge |
| busWackId | input | ID_W | ID of the acknowledge |

## Verification
The checks assume a single-beat slave. It accepts one address, then exchanges exactly one data beat for it, and it acknowledges a store only after taking that store's data. The checks also assume the processor holds its request fields only for the cycle in which `reqValid` is sampled. The directed stimulus plays that slave itself. It answers each phase only after seeing the matching valid, inserts address stalls and acknowledge delays, and on one load injects a beat with a foreign ID before the real one. It never asserts two responses in the same cycle.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WACK,
    ST_RESP
  } splitState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic takeRead;  // store the current read beat
    logic nextId;    // transaction finished, advance the ID
    logic beat;      // 0 = lower word, 1 = upper word
  } splitStrobe_t;

endpackage

// File: rtl/splitter_datapath.sv
module splitter_datapath
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  splitStrobe_t        strobe,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic [ID_W-1:0]     busRdataId,
  input  logic [ID_W-1:0]     busWackId,
  output logic                writeQ,
  output logic                split,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [ID_W-1:0]     busId,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W/8-1:0] busStrb,
  output logic                rdIdOk,
  output logic                wackIdOk,
  output logic [DATA_W-1:0]   respRdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int NB_W  = OFF_W + 1;
  localparam int SH_W  = OFF_W + 3;

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdLo, rdHi;
  logic [ID_W-1:0]   idQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      rdLo   <= '0;
      rdHi   <= '0;
      idQ    <= '0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        writeQ <= reqWrite;
        wdataQ <= reqWdata;
        rdLo   <= '0;
        rdHi   <= '0;
      end
      if (strobe.takeRead) begin
        if (strobe.beat) rdHi <= busRdata;
        else             rdLo <= busRdata;
      end
      if (strobe.nextId) idQ <= idQ + ID_W'(1);
    end
  end

  logic [NB_W-1:0]        nBytes;
  logic [OFF_W-1:0]       offset;
  logic [SH_W-1:0]        shiftBits;
  logic [2*LANES-1:0]     widthOnes, laneMask;
  logic [2*DATA_W-1:0]    wideW;
  logic [ADDR_W-1:0]      baseAddr;
  logic [DATA_W-1:0]      readAligned, keepMask;

  assign nBytes    = NB_W'(1) << sizeQ;
  assign offset    = addrQ[OFF_W-1:0];
  assign shiftBits = {offset, 3'b000};
  assign widthOnes = ~({(2*LANES){1'b1}} << nBytes);
  assign laneMask  = widthOnes << offset;
  assign split     = |laneMask[2*LANES-1:LANES];

  assign wideW    = {{DATA_W{1'b0}}, wdataQ} << shiftBits;
  assign busWdata = strobe.beat ? wideW[2*DATA_W-1:DATA_W] : wideW[DATA_W-1:0];
  assign busStrb  = strobe.beat ? laneMask[2*LANES-1:LANES] : laneMask[LANES-1:0];

  assign baseAddr = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign busAddr  = strobe.beat ? baseAddr + ADDR_W'(LANES) : baseAddr;
  assign busId    = idQ;
  assign rdIdOk   = (busRdataId == idQ);
  assign wackIdOk = (busWackId == idQ);

  assign readAligned = DATA_W'({rdHi, rdLo} >> shiftBits);

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keepMask[8*i +: 8] = {8{NB_W'(i) < nBytes}};
  end

  assign respRdata = writeQ ? '0 : (readAligned & keepMask);

endmodule

// File: rtl/splitter_ctrl.sv
module splitter_ctrl
  import splitter_pkg::*;
#(
  parameter bit WAIT_WR_ACK = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         writeQ,
  input  logic         split,
  input  logic         busAddrReady,
  input  logic         busWdataReady,
  input  logic         busRdataValid,
  input  logic         rdIdOk,
  input  logic         busWackValid,
  input  logic         wackIdOk,
  output logic         reqReady,
  output logic         busAddrValid,
  output logic         busWdataValid,
  output logic         busRdataReady,
  output logic         respValid,
  output splitStrobe_t strobe
);
  splitState_t state, nextState;
  logic beatQ, beatD, beatDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beatQ <= 1'b0;
    end else begin
      state <= nextState;
      beatQ <= beatD;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.beat = beatQ;
    nextState   = state;
    beatD       = beatQ;
    beatDone    = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        beatD       = 1'b0;
        nextState   = ST_ADDR;
      end
      ST_ADDR: if (busAddrReady) nextState = ST_DATA;
      ST_DATA: begin
        if (writeQ) begin
          if (busWdataReady) begin
            if (WAIT_WR_ACK) nextState = ST_WACK;
            else             beatDone  = 1'b1;
          end
        end else if (busRdataValid && rdIdOk) begin
          strobe.takeRead = 1'b1;
          beatDone        = 1'b1;
        end
      end
      ST_WACK: if (busWackValid && wackIdOk) beatDone = 1'b1;
      ST_RESP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    if (beatDone) begin
      strobe.nextId = 1'b1;
      if (!beatQ && split) begin
        beatD     = 1'b1;
        nextState = ST_ADDR;
      end else begin
        nextState = ST_RESP;
      end
    end
  end

  assign reqReady      = (state == ST_IDLE);
  assign busAddrValid  = (state == ST_ADDR);
  assign busWdataValid = (state == ST_DATA) && writeQ;
  assign busRdataReady = (state == ST_DATA) && !writeQ;
  assign respValid     = (state == ST_RESP);

endmodule

// File: rtl/unaligned_bus_splitter.sv
module unaligned_bus_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int ID_W        = 4,
  parameter int LEN_W       = 4,
  parameter bit WAIT_WR_ACK = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                respValid,
  output logic [DATA_W-1:0]   respRdata,
  output logic                busAddrValid,
  input  logic                busAddrReady,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [ID_W-1:0]     busId,
  output logic [LEN_W-1:0]    busLen,
  output logic                busWrite,
  output logic                busWdataValid,
  input  logic                busWdataReady,
  output logic [ID_W-1:0]     busWdataId,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W/8-1:0] busStrb,
  input  logic                busRdataValid,
  output logic                busRdataReady,
  input  logic [ID_W-1:0]     busRdataId,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busWackValid,
  input  logic [ID_W-1:0]     busWackId
);
  splitStrobe_t strobe;
  logic writeQ, split, rdIdOk, wackIdOk;

  splitter_ctrl #(.WAIT_WR_ACK(WAIT_WR_ACK)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .writeQ(writeQ), .split(split),
    .busAddrReady(busAddrReady), .busWdataReady(busWdataReady),
    .busRdataValid(busRdataValid), .rdIdOk(rdIdOk),
    .busWackValid(busWackValid), .wackIdOk(wackIdOk),
    .reqReady(reqReady), .busAddrValid(busAddrValid), .busWdataValid(busWdataValid),
    .busRdataReady(busRdataReady), .respValid(respValid), .strobe(strobe)
  );

  splitter_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .busRdata(busRdata), .busRdataId(busRdataId),
    .busWackId(busWackId), .writeQ(writeQ), .split(split), .busAddr(busAddr),
    .busId(busId), .busWdata(busWdata), .busStrb(busStrb), .rdIdOk(rdIdOk),
    .wackIdOk(wackIdOk), .respRdata(respRdata)
  );

  assign busLen     = '0;
  assign busWrite   = writeQ;
  assign busWdataId = busId;

endmodule

// File: rtl/splitter_checks.sv
module splitter_checks #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 4,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              respValid,
  input logic              busAddrValid,
  input logic              busAddrReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [ID_W-1:0]   busId,
  input logic [LEN_W-1:0]  busLen,
  input logic              busWdataValid,
  input logic [LANES-1:0]  busStrb
);
  localparam int OFF_W = $clog2(LANES);

  logic            seenAccept;
  logic [ID_W-1:0] lastId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenAccept <= 1'b0;
      lastId     <= '0;
    end else if (busAddrValid && busAddrReady) begin
      seenAccept <= 1'b1;
      lastId     <= busId;
    end
  end

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid |-> (busAddr[OFF_W-1:0] == '0) && (busLen == '0));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrValid && !busAddrReady) |=> busAddrValid && $stable(busAddr) && $stable(busId));

  assert_data_after_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWdataValid) |-> $past(busAddrValid && busAddrReady));

  assert_id_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrValid && busAddrReady && seenAccept) |-> (busId == lastId + ID_W'(1)));

  assert_strb_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWdataValid |-> (busStrb != '0));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady);

endmodule

bind unaligned_bus_splitter splitter_checks #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W), .LANES(DATA_W/8)
) u_checks (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .respValid(respValid),
  .busAddrValid(busAddrValid), .busAddrReady(busAddrReady), .busAddr(busAddr),
  .busId(busId), .busLen(busLen), .busWdataValid(busWdataValid), .busStrb(busStrb)
);

// File: tb/unaligned_bus_splitter_test.sv
`timescale 1ns/1ps
module unaligned_bus_splitter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWdata = '0;
  logic        reqReady, respValid;
  logic [63:0] respRdata;
  logic        busAddrValid, busWrite, busWdataValid, busRdataReady;
  logic        busAddrReady = 1'b0, busWdataReady = 1'b0;
  logic        busRdataValid = 1'b0, busWackValid = 1'b0;
  logic [3:0]  busRdataId = '0, busWackId = '0;
  logic [63:0] busRdata = '0;
  logic [31:0] busAddr;
  logic [3:0]  busId, busLen, busWdataId;
  logic [63:0] busWdata;
  logic [7:0]  busStrb;

  int checks = 0;
  int failures = 0;
  logic [3:0] expId = '0;

  always #2.5 clk = ~clk;

  unaligned_bus_splitter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .respValid(respValid), .respRdata(respRdata), .busAddrValid(busAddrValid),
    .busAddrReady(busAddrReady), .busAddr(busAddr), .busId(busId), .busLen(busLen),
    .busWrite(busWrite), .busWdataValid(busWdataValid), .busWdataReady(busWdataReady),
    .busWdataId(busWdataId), .busWdata(busWdata), .busStrb(busStrb),
    .busRdataValid(busRdataValid), .busRdataReady(busRdataReady),
    .busRdataId(busRdataId), .busRdata(busRdata), .busWackValid(busWackValid),
    .busWackId(busWackId)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA7;
  endfunction

  function automatic logic [63:0] memWord(input logic [31:0] base);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = byteAt(base + 32'(i));
    return w;
  endfunction

  // one processor access, with the bench acting as the bus slave
  task automatic runAccess(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                           input logic [63:0] wd, input int addrStall,
                           input int ackDelay, input bit badIdFirst);
    int nb, off, beats;
    logic [7:0]  strbExp [2];
    logic [63:0] dataExp [2];
    logic [63:0] rdExp;
    logic [31:0] base;
    nb = 1 << sz;
    off = int'(a[2:0]);
    beats = (off + nb > 8) ? 2 : 1;
    base = {a[31:3], 3'b000};
    strbExp[0] = '0; strbExp[1] = '0; dataExp[0] = '0; dataExp[1] = '0;
    for (int k = 0; k < nb; k++) begin
      int lane = off + k;
      strbExp[lane / 8][lane % 8] = 1'b1;
      dataExp[lane / 8][8*(lane % 8) +: 8] = wd[8*k +: 8];
    end
    rdExp = '0;
    for (int k = 0; k < nb; k++) rdExp[8*k +: 8] = byteAt(a + 32'(k));

    @(negedge clk);
    check("R10", "reqReady before request", {63'b0, reqReady}, 64'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = '0;
    for (int b = 0; b < beats; b++) begin
      for (int s = 0; s < addrStall; s++) begin
        check("R5", "address held while stalled", {63'b0, busAddrValid}, 64'd1);
        @(negedge clk);
      end
      check(beats == 2 ? "R4" : "R3", "busAddrValid", {63'b0, busAddrValid}, 64'd1);
      check(beats == 2 ? "R4" : "R2", "busAddr", {32'b0, busAddr}, {32'b0, base + 32'(8*b)});
      check("R2", "busLen", {60'b0, busLen}, 64'd0);
      check("R6", "busId", {60'b0, busId}, {60'b0, expId});
      check("R5", "busWrite", {63'b0, busWrite}, {63'b0, wr});
      busAddrReady = 1'b1;
      @(negedge clk);
      busAddrReady = 1'b0;
      if (wr) begin
        check("R5", "busWdataValid", {63'b0, busWdataValid}, 64'd1);
        check("R5", "busWdataId", {60'b0, busWdataId}, {60'b0, expId});
        check(beats == 2 ? "R4" : "R3", "busStrb", {56'b0, busStrb}, {56'b0, strbExp[b]});
        for (int l = 0; l < 8; l++)
          if (strbExp[b][l])
            check("R7", "write lane", {56'b0, busWdata[8*l +: 8]}, {56'b0, dataExp[b][8*l +: 8]});
        busWdataReady = 1'b1;
        @(negedge clk);
        busWdataReady = 1'b0;
        for (int d = 0; d < ackDelay; d++) begin
          check("R9", "no address before ack", {63'b0, busAddrValid}, 64'd0);
          check("R9", "no response before ack", {63'b0, respValid}, 64'd0);
          @(negedge clk);
        end
        busWackValid = 1'b1; busWackId = expId;
        @(negedge clk);
        busWackValid = 1'b0;
      end else begin
        check("R8", "busRdataReady", {63'b0, busRdataReady}, 64'd1);
        if (badIdFirst && b == 0) begin
          busRdataValid = 1'b1; busRdataId = expId + 4'd1; busRdata = '1;
          @(negedge clk);
          busRdataValid = 1'b0;
          check("R8", "foreign-ID beat ignored", {63'b0, busRdataReady}, 64'd1);
        end
        busRdataValid = 1'b1; busRdataId = expId; busRdata = memWord(base + 32'(8*b));
        @(negedge clk);
        busRdataValid = 1'b0; busRdata = '0;
      end
      expId = expId + 4'd1;
    end
    check("R10", "respValid after last half", {63'b0, respValid}, 64'd1);
    if (!wr) check("R8", "respRdata", respRdata, rdExp);
    @(negedge clk);
    check("R10", "respValid single cycle", {63'b0, respValid}, 64'd0);
    check("R10", "ready again", {63'b0, reqReady}, 64'd1);
  endtask

  task automatic testReset();
    check("R1", "reqReady", {63'b0, reqReady}, 64'd1);
    check("R1", "busAddrValid", {63'b0, busAddrValid}, 64'd0);
    check("R1", "busWdataValid", {63'b0, busWdataValid}, 64'd0);
    check("R1", "respValid", {63'b0, respValid}, 64'd0);
  endtask

  task automatic testAlignedWrite();   runAccess(1'b1, 32'h1000, 2'd3, 64'h8877665544332211, 0, 0, 1'b0); endtask
  task automatic testSplitWrite();     runAccess(1'b1, 32'h1004, 2'd3, 64'hF0E0D0C0B0A09080, 0, 1, 1'b0); endtask
  task automatic testHalfWrite();      runAccess(1'b1, 32'h1001, 2'd1, 64'h000000000000BEEF, 0, 0, 1'b0); endtask
  task automatic testByteWrite();      runAccess(1'b1, 32'h1003, 2'd0, 64'h00000000000000C3, 1, 0, 1'b0); endtask
  task automatic testStalledSplitWr(); runAccess(1'b1, 32'h10FE, 2'd2, 64'h00000000DEADBEEF, 2, 3, 1'b0); endtask
  task automatic testHalfRead();       runAccess(1'b0, 32'h1001, 2'd1, 64'h0, 0, 0, 1'b0); endtask
  task automatic testSplitRead8();     runAccess(1'b0, 32'h100C, 2'd3, 64'h0, 0, 0, 1'b1); endtask
  task automatic testSplitRead4();     runAccess(1'b0, 32'h2006, 2'd2, 64'h0, 1, 0, 1'b0); endtask
  task automatic testByteRead();       runAccess(1'b0, 32'h0007, 2'd0, 64'h0, 0, 0, 1'b0); endtask
  task automatic testAlignedRead();    runAccess(1'b0, 32'h2000, 2'd3, 64'h0, 2, 0, 1'b0); endtask

  task automatic testIdWrap();  // R6: IDs roll over past 2^ID_W-1
    for (int i = 0; i < 6; i++) runAccess(1'b0, 32'h3005 + 32'(i), 2'd1, 64'h0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAlignedWrite();
    testSplitWrite();
    testHalfWrite();
    testByteWrite();
    testStalledSplitWr();
    testHalfRead();
    testSplitRead8();
    testSplitRead4();
    testByteRead();
    testAlignedRead();
    testIdWrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule